// File: doc/BRIEF.md
# Barrier-Gated Instruction Sequencer

This block is the control core of a small tensor accelerator. It holds a short program of fixed 128-bit instruction words in a local instruction store, steps through them in order, decodes each word and hands it to one of two execution units. Data-movement words go to a DMA unit. Clear, matrix-multiply and vector words go to a compute unit. Each hand-off uses a valid/ready handshake. Each unit signals finished work with a one-cycle completion pulse. The sequencer does no hazard detection. Ordering between data movement and compute comes only from explicit barrier words, which hold issue until every accepted operation in both units has completed.

A host loads the program through a write port into the store. It launches execution with a start write on a small MMIO port and reads status and three performance counters back over the same port. A halt word ends the program and raises a done flag. An undefined opcode, or a data-movement or compute word whose target mask is zero, stops execution and raises a sticky error flag. The target byte selects which core-local memories and matrix units the operation is meant for. The sequencer only checks that it is nonzero and passes the whole word on unchanged.

Top module: `instr_seq`

## Requirements
- R1: After reset the program counter is 0, the block is idle, busy/done/error are 0, all three counters read 0 and neither valid output is asserted.
- R2: A write with bit 0 set to MMIO address 0 while the block is not running starts execution at instruction address 0, clears done, error and all counters. The same write while running is ignored.
- R3: The opcode is bits 127:120 and the target mask is bits 111:104. Opcode 0x01 is DMA, 0x02/0x03/0x04 are compute (clear, matmul, vector), 0x05 is barrier, 0x06 is halt and 0x00 is no-op. The full 128-bit word is presented on dma_instr or cmp_instr while it is offered.
- R4: At most one instruction is offered at a time, in program order. A DMA or compute word stays offered until its unit's ready is high, then retires in that cycle.
- R5: A barrier retires only in a cycle where both units have zero outstanding operations. Each cycle it waits, the program counter holds.
- R6: Each unit may have at most 2^OUT_W-1 operations accepted but not completed. At that count no further word is offered to that unit.
- R7: A halt word retires, sets done, clears busy, and nothing further is offered until the next start.
- R8: An opcode outside 0x00 to 0x06, or a target mask of 0 on a DMA or compute word, sets error (sticky until the next start), stops execution, and the word is neither offered nor retired.
- R9: The counters hold the instructions retired (including halt), the cycles a barrier waited, and the cycles spent running from start up to and including the halting or faulting cycle.
- R10: MMIO reads are combinational. Address 0 returns {error, done, busy} in bits 2:0. Addresses 1, 2 and 3 return the retired, barrier-wait and running-cycle counters. Any other address returns 0.
- R11: A no-op retires in one cycle whatever its target mask, including zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_we | input | 1 | Instruction store write enable |
| ld_addr | input | $clog2(IMEM_DEPTH) | Instruction store write address |
| ld_data | input | 128 | Instruction word to store |
| mmio_we | input | 1 | MMIO write strobe |
| mmio_addr | input | MMIO_AW | MMIO register address |
| mmio_wdata | input | MMIO_DW | MMIO write data |
| mmio_rdata | output | MMIO_DW | MMIO read data |
| dma_valid | output | 1 | DMA word offered |
| dma_ready | input | 1 | DMA unit accepts |
| dma_instr | output | 128 | Offered DMA word |
| dma_done | input | 1 | One DMA operation completed |
| cmp_valid | output | 1 | Compute word offered |
| cmp_ready | input | 1 | Compute unit accepts |
| cmp_instr | output | 128 | Offered compute word |
| cmp_done | input | 1 | One compute operation completed |
| busy | output | 1 | Program running |
| done | output | 1 | Program halted normally |
| error | output | 1 | Program stopped on a faulting word |

## Verification
Every cycle, the assertions check these rules: offers are exclusive and happen only while running, the program counter holds during a waiting barrier, no unit is offered work at its outstanding limit, done and error stay set until a new start, and the retired count never falls. Other behaviour only shows up in the bench's program runs against a cycle model. That covers exact issue order and word contents, barrier wait counts under random ready and completion timing, and the fault cases for a bad opcode and a zero target. It also covers the ignored mid-run start and the counter values read back over MMIO.

// File: rtl/iseq_pkg.sv
package iseq_pkg;
   localparam int INSTR_W   = 128;
   localparam int NUM_UNITS = 2;
   localparam int UNIT_DMA  = 0;
   localparam int UNIT_CMP  = 1;

   localparam logic [7:0] OP_NOP  = 8'h00;
   localparam logic [7:0] OP_DMA  = 8'h01;
   localparam logic [7:0] OP_CLR  = 8'h02;
   localparam logic [7:0] OP_MMUL = 8'h03;
   localparam logic [7:0] OP_VEC  = 8'h04;
   localparam logic [7:0] OP_BAR  = 8'h05;
   localparam logic [7:0] OP_HALT = 8'h06;

   typedef enum logic [2:0] {K_NOP, K_DMA, K_CMP, K_BAR, K_HALT, K_BAD} kind_e;
   typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE, S_FAULT} st_e;

   typedef struct packed {
      kind_e      kind;
      logic [7:0] target;
      logic [7:0] flags;
   } dec_t;
endpackage

// File: rtl/iseq_decode.sv
module iseq_decode
   import iseq_pkg::*;
(
   input  logic [INSTR_W-1:0] word,
   output dec_t               dec
);
   logic [7:0] opc;
   logic       needs_tgt;

   always_comb begin
      opc        = word[127:120];
      dec.flags  = word[119:112];
      dec.target = word[111:104];
      needs_tgt  = 1'b0;
      unique case (opc)
         OP_NOP:                 dec.kind = K_NOP;
         OP_DMA:  begin          dec.kind = K_DMA; needs_tgt = 1'b1; end
         OP_CLR, OP_MMUL, OP_VEC:
                  begin          dec.kind = K_CMP; needs_tgt = 1'b1; end
         OP_BAR:                 dec.kind = K_BAR;
         OP_HALT:                dec.kind = K_HALT;
         default:                dec.kind = K_BAD;
      endcase
      if (needs_tgt && dec.target == 8'h00) dec.kind = K_BAD;
   end
endmodule

// File: rtl/iseq_track.sv
module iseq_track #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         full,
   output logic         empty
);
   if (W < 1) begin : g_bad_w
      $error("iseq_track: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         case ({inc, dec})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign cnt   = cnt_q;
   assign full  = (cnt_q == '1);
   assign empty = (cnt_q == '0);
endmodule

// File: rtl/iseq_perf.sv
module iseq_perf #(
   parameter int CNT_W = 32,
   parameter int DW    = 32,
   parameter int AW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [2:0]       bump,
   input  logic [2:0]       status,
   input  logic [AW-1:0]    rd_addr,
   output logic [DW-1:0]    rd_data,
   output logic [CNT_W-1:0] retired
);
   localparam int NCNT = 3;

   if (DW < 3 || CNT_W > DW || AW < 2) begin : g_bad_cfg
      $error("iseq_perf: need DW >= 3, CNT_W <= DW, AW >= 2");
   end

   logic [NCNT-1:0][CNT_W-1:0] cnt_q;

   for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         cnt_q[gi] <= '0;
         else if (clr)       cnt_q[gi] <= '0;
         else if (bump[gi])  cnt_q[gi] <= cnt_q[gi] + 1'b1;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == '0) rd_data[2:0] = status;
      for (int i = 0; i < NCNT; i++) begin
         if (rd_addr == AW'(i + 1)) rd_data = DW'(cnt_q[i]);
      end
   end

   assign retired = cnt_q[0];
endmodule

// File: rtl/instr_seq.sv
module instr_seq
   import iseq_pkg::*;
#(
   parameter int IMEM_DEPTH = 16,
   parameter int OUT_W      = 3,
   parameter int CNT_W      = 32,
   parameter int MMIO_AW    = 4,
   parameter int MMIO_DW    = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ld_we,
   input  logic [$clog2(IMEM_DEPTH)-1:0] ld_addr,
   input  logic [127:0]                  ld_data,
   input  logic                          mmio_we,
   input  logic [MMIO_AW-1:0]            mmio_addr,
   input  logic [MMIO_DW-1:0]            mmio_wdata,
   output logic [MMIO_DW-1:0]            mmio_rdata,
   output logic                          dma_valid,
   input  logic                          dma_ready,
   output logic [127:0]                  dma_instr,
   input  logic                          dma_done,
   output logic                          cmp_valid,
   input  logic                          cmp_ready,
   output logic [127:0]                  cmp_instr,
   input  logic                          cmp_done,
   output logic                          busy,
   output logic                          done,
   output logic                          error
);
   localparam int PC_W = $clog2(IMEM_DEPTH);

   if (IMEM_DEPTH < 2 || (IMEM_DEPTH & (IMEM_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("instr_seq: IMEM_DEPTH must be a power of two, at least 2");
   end
   if (OUT_W < 1 || OUT_W > 16) begin : g_bad_out
      $error("instr_seq: OUT_W out of range");
   end

   // instruction store
   logic [INSTR_W-1:0] mem [IMEM_DEPTH];
   always_ff @(posedge clk) begin
      if (ld_we) mem[ld_addr] <= ld_data;
   end

   st_e             state_q;
   logic [PC_W-1:0] pc_q;
   logic [INSTR_W-1:0] word;
   dec_t            dec;

   assign word = mem[pc_q];

   iseq_decode u_dec (.word(word), .dec(dec));

   logic running, start_acc;
   assign running   = (state_q == S_RUN);
   assign start_acc = mmio_we && (mmio_addr == '0) && mmio_wdata[0] && !running;

   // outstanding trackers, one per unit
   logic [NUM_UNITS-1:0][OUT_W-1:0] ocnt;
   logic [NUM_UNITS-1:0]            full, empty, hs, cpl;

   assign hs[UNIT_DMA]  = dma_valid && dma_ready;
   assign hs[UNIT_CMP]  = cmp_valid && cmp_ready;
   assign cpl[UNIT_DMA] = dma_done;
   assign cpl[UNIT_CMP] = cmp_done;

   for (genvar gu = 0; gu < NUM_UNITS; gu++) begin : g_unit
      iseq_track #(.W(OUT_W)) u_trk (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (hs[gu]),
         .dec   (cpl[gu]),
         .cnt   (ocnt[gu]),
         .full  (full[gu]),
         .empty (empty[gu])
      );
   end

   logic drained, is_bar, advance, stall_tick;
   assign drained = &empty;
   assign is_bar  = (dec.kind == K_BAR);

   assign dma_valid = running && (dec.kind == K_DMA) && !full[UNIT_DMA];
   assign cmp_valid = running && (dec.kind == K_CMP) && !full[UNIT_CMP];
   assign dma_instr = word;
   assign cmp_instr = word;

   always_comb begin
      advance = 1'b0;
      if (running) begin
         unique case (dec.kind)
            K_NOP, K_HALT: advance = 1'b1;
            K_DMA:         advance = hs[UNIT_DMA];
            K_CMP:         advance = hs[UNIT_CMP];
            K_BAR:         advance = drained;
            default:       advance = 1'b0;
         endcase
      end
   end
   assign stall_tick = running && is_bar && !drained;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         pc_q    <= '0;
      end else if (start_acc) begin
         state_q <= S_RUN;
         pc_q    <= '0;
      end else if (running) begin
         if (dec.kind == K_BAD) begin
            state_q <= S_FAULT;
         end else if (advance) begin
            pc_q <= pc_q + 1'b1;
            if (dec.kind == K_HALT) state_q <= S_DONE;
         end
      end
   end

   assign busy  = running;
   assign done  = (state_q == S_DONE);
   assign error = (state_q == S_FAULT);

   logic [CNT_W-1:0] retired;

   iseq_perf #(.CNT_W(CNT_W), .DW(MMIO_DW), .AW(MMIO_AW)) u_perf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_acc),
      .bump    ({running, stall_tick, advance}),
      .status  ({error, done, busy}),
      .rd_addr (mmio_addr),
      .rd_data (mmio_rdata),
      .retired (retired)
   );
endmodule

// File: rtl/instr_seq_chk.sv
module instr_seq_chk #(
   parameter int OUT_W = 3,
   parameter int PC_W  = 4,
   parameter int CNT_W = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  running,
   input logic                  halted,
   input logic                  faulted,
   input logic                  start_acc,
   input logic [PC_W-1:0]       pc,
   input logic                  is_bar,
   input logic                  drained,
   input logic                  dma_valid,
   input logic                  cmp_valid,
   input logic [1:0][OUT_W-1:0] ocnt,
   input logic [CNT_W-1:0]      retired
);
   localparam logic [OUT_W-1:0] LIMIT = '1;

   a_r4_one_offer: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dma_valid, cmp_valid}));

   a_r4_offer_when_running: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_valid || cmp_valid) |-> running);

   a_r5_barrier_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (running && is_bar && !drained) |=> $stable(pc));

   a_r6_dma_limit: assert property (@(posedge clk) disable iff (!rst_n)
      dma_valid |-> (ocnt[0] != LIMIT));

   a_r6_cmp_limit: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |-> (ocnt[1] != LIMIT));

   a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !start_acc) |=> halted);

   a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (faulted && !start_acc) |=> faulted);

   a_r9_retired_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      !start_acc |=> (retired >= $past(retired)));
endmodule

bind instr_seq instr_seq_chk #(.OUT_W(OUT_W), .PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .running   (running),
   .halted    (done),
   .faulted   (error),
   .start_acc (start_acc),
   .pc        (pc_q),
   .is_bar    (is_bar),
   .drained   (drained),
   .dma_valid (dma_valid),
   .cmp_valid (cmp_valid),
   .ocnt      (ocnt),
   .retired   (retired)
);

// File: tb/instr_seq_bench.sv
`timescale 1ns/1ps
module instr_seq_bench;
   localparam int DEPTH = 16;
   localparam int OUT_W = 3;
   localparam int OMAX  = (1 << OUT_W) - 1;
   localparam int KN = 0, KD = 1, KC = 2, KB = 3, KH = 4, KX = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic         ld_we = 1'b0;
   logic [3:0]   ld_addr = '0;
   logic [127:0] ld_data = '0;
   logic         mmio_we = 1'b0;
   logic [3:0]   mmio_addr = '0;
   logic [31:0]  mmio_wdata = '0;
   logic [31:0]  mmio_rdata;
   logic         dma_valid, cmp_valid, busy, done, error;
   logic         dma_ready = 1'b0, cmp_ready = 1'b0, dma_done = 1'b0, cmp_done = 1'b0;
   logic [127:0] dma_instr, cmp_instr;

   instr_seq #(.IMEM_DEPTH(DEPTH), .OUT_W(OUT_W)) u_instr_seq (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
      .mmio_we(mmio_we), .mmio_addr(mmio_addr), .mmio_wdata(mmio_wdata), .mmio_rdata(mmio_rdata),
      .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_instr(dma_instr), .dma_done(dma_done),
      .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_instr(cmp_instr), .cmp_done(cmp_done),
      .busy(busy), .done(done), .error(error));

   int n_chk = 0, n_bad = 0;
   int mo_d = 0, mo_c = 0, cap_seen = 0;
   logic [127:0] prog [DEPTH];
   int n_prog = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int kind_of(input logic [127:0] w);
      logic [7:0] op, tg;
      op = w[127:120];
      tg = w[111:104];
      case (op)
         8'h00: return KN;
         8'h01: return (tg == 0) ? KX : KD;
         8'h02, 8'h03, 8'h04: return (tg == 0) ? KX : KC;
         8'h05: return KB;
         8'h06: return KH;
         default: return KX;
      endcase
   endfunction

   function automatic logic [127:0] mk(input logic [7:0] op, input logic [7:0] tg);
      return {op, 8'($urandom), tg, 8'h00, 32'($urandom), 32'($urandom), 32'($urandom)};
   endfunction

   function automatic logic [7:0] tgt();
      return 8'(1 + ($urandom % 255));
   endfunction

   task automatic load();
      for (int i = 0; i < n_prog; i++) begin
         @(negedge clk);
         ld_we = 1'b1; ld_addr = 4'(i); ld_data = prog[i];
      end
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      mmio_we = 1'b0; mmio_addr = a;
      #1 d = mmio_rdata;
   endtask

   task automatic drain();
      @(negedge clk);
      mmio_we = 1'b0; dma_ready = 1'b0; cmp_ready = 1'b0;
      dma_done = 1'b0; cmp_done = 1'b0;
      while (mo_d > 0 || mo_c > 0) begin
         dma_done = (mo_d > 0);
         cmp_done = (mo_c > 0);
         if (dma_done) mo_d--;
         if (cmp_done) mo_c--;
         @(negedge clk);
      end
      dma_done = 1'b0; cmp_done = 1'b0;
   endtask

   // runs the loaded program against a cycle model, then checks results over MMIO
   task automatic run(input string tag, input int p_rdy, input int p_done, input int inj);
      int idx = 0, cyc = 0, ret = 0, stl = 0, tot = 0, k;
      bit live = 1'b1, flt = 1'b0, adv, ev, cv, hd, hc;
      logic [127:0] cur;
      logic [31:0] d;
      cap_seen = 0;
      @(negedge clk);
      mmio_we = 1'b1; mmio_addr = '0; mmio_wdata = 32'h1;
      while (live && cyc < 4000) begin
         @(negedge clk);
         mmio_we   = (cyc == inj);
         dma_ready = (($urandom % 100) < p_rdy);
         cmp_ready = (($urandom % 100) < p_rdy);
         dma_done  = (mo_d > 0) && (($urandom % 100) < p_done);
         cmp_done  = (mo_c > 0) && (($urandom % 100) < p_done);
         #1;
         cur = prog[idx];
         k = kind_of(cur);
         tot++;
         ev = (k == KD) && (mo_d < OMAX);
         cv = (k == KC) && (mo_c < OMAX);
         if (k == KD && mo_d == OMAX) cap_seen++;
         chk((dma_valid === ev) && (cmp_valid === cv), "R4", "offer pattern (R6 limit)",
             {dma_valid, cmp_valid}, {ev, cv});
         hd = ev && dma_ready;
         hc = cv && cmp_ready;
         if (ev) chk(dma_instr === cur, "R3", "dma word", dma_instr, cur);
         if (cv) chk(cmp_instr === cur, "R3", "compute word", cmp_instr, cur);
         adv = 1'b0;
         case (k)
            KN, KH: adv = 1'b1;
            KD: adv = hd;
            KC: adv = hc;
            KB: if (mo_d == 0 && mo_c == 0) adv = 1'b1; else stl++;
            default: begin live = 1'b0; flt = 1'b1; end
         endcase
         if (adv) begin
            ret++;
            if (k == KH) live = 1'b0;
            idx++;
         end
         mo_d = mo_d + int'(hd) - int'(dma_done);
         mo_c = mo_c + int'(hc) - int'(cmp_done);
         cyc++;
      end
      drain();
      chk(dma_valid === 1'b0 && cmp_valid === 1'b0, flt ? "R8" : "R7", "no offer after stop",
          {dma_valid, cmp_valid}, 0);
      rd(4'd0, d);
      chk(d === (flt ? 32'h4 : 32'h2), flt ? "R8" : "R7", {tag, " status"}, d, flt ? 32'h4 : 32'h2);
      rd(4'd1, d);
      chk(d === 32'(ret), "R9", {tag, " retired"}, d, ret);
      rd(4'd2, d);
      chk(d === 32'(stl), "R9", {tag, " barrier wait"}, d, stl);
      rd(4'd3, d);
      chk(d === 32'(tot), "R10", {tag, " running cycles"}, d, tot);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, R10 unmapped address
      rd(4'd0, d); chk(d === 0, "R1", "status after reset", d, 0);
      for (int a = 1; a < 4; a++) begin
         rd(4'(a), d); chk(d === 0, "R1", "counter after reset", d, 0);
      end
      rd(4'd9, d); chk(d === 0, "R10", "unmapped read", d, 0);
      chk(dma_valid === 0 && cmp_valid === 0 && busy === 0, "R1", "idle outputs",
          {dma_valid, cmp_valid, busy}, 0);

      // reference flow: two loads, barrier, clear, multiply, barrier, store, halt
      prog[0] = mk(8'h01, tgt()); prog[1] = mk(8'h01, tgt()); prog[2] = mk(8'h05, 8'h00);
      prog[3] = mk(8'h02, tgt()); prog[4] = mk(8'h03, tgt()); prog[5] = mk(8'h05, 8'h00);
      prog[6] = mk(8'h01, tgt()); prog[7] = mk(8'h06, 8'h00);
      n_prog = 8; load();
      run("R5 reference fast", 100, 30, -1);
      run("R5 reference slow", 50, 10, -1);
      // R2 start written mid-run is ignored: counters must still match the model
      run("R2 restart ignored", 60, 20, 3);

      // R6 outstanding limit
      for (int i = 0; i < 12; i++) prog[i] = mk(8'h01, tgt());
      prog[12] = mk(8'h05, 8'h00); prog[13] = mk(8'h06, tgt());
      n_prog = 14; load();
      run("R6 cap", 100, 2, -1);
      chk(cap_seen > 0, "R6", "limit reached", cap_seen, 1);

      // R11 no-op with any target
      prog[0] = mk(8'h00, 8'h00); prog[1] = mk(8'h00, 8'hff); prog[2] = mk(8'h06, 8'h00);
      n_prog = 3; load();
      run("R11 nop", 100, 50, -1);

      // R8 unknown opcode
      prog[0] = mk(8'h01, tgt()); prog[1] = mk(8'h7f, tgt()); prog[2] = mk(8'h06, 8'h00);
      n_prog = 3; load();
      run("R8 bad opcode", 100, 50, -1);
      // R8 zero target on DMA
      prog[0] = mk(8'h04, tgt()); prog[1] = mk(8'h01, 8'h00); prog[2] = mk(8'h06, 8'h00);
      n_prog = 3; load();
      run("R8 zero target", 100, 50, -1);

      // random programs, R3 R4 R5 R9 across mixes
      for (int t = 0; t < 24; t++) begin
         n_prog = 3 + ($urandom % 13);
         for (int i = 0; i < n_prog - 1; i++) begin
            case ($urandom % 5)
               0: prog[i] = mk(8'h00, 8'($urandom));
               1: prog[i] = mk(8'h01, tgt());
               2: prog[i] = mk(8'(2 + ($urandom % 3)), tgt());
               3: prog[i] = mk(8'h05, 8'($urandom));
               default: prog[i] = mk(8'h01, tgt());
            endcase
         end
         prog[n_prog - 1] = mk(8'h06, 8'($urandom));
         load();
         run("R3 random", 20 + ($urandom % 81), 5 + ($urandom % 60), -1);
      end

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule